// File: doc/BRIEF.md
# Low-Power Mode and Clock Gating Controller

This block tracks the operating state of a small microcontroller (RUN, HALT or SLEEP) and produces the run enables for four clock sources plus an enable for the CPU clock. When the processor issues a wait-for-interrupt or wait-for-event strobe, the controller gates the CPU clock. It then either leaves every enabled source running (HALT) or stops all sources except the ones software has marked to stay alive (SLEEP).

A peripheral interrupt, a watchdog NMI or a reset request wakes the controller back to RUN. A reset request also forces the internal oscillator back in as system clock. Software picks the system clock with a 2-bit select. The selected source can never be switched off while the CPU is in RUN or HALT. Sources that are not selected follow their individual software enables.

Top module: `pmu_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, `mode` is RUN (encoding 0 = RUN, 1 = HALT, 2 = SLEEP), `cpu_clk_en` is 1 and the internal oscillator (source index 0) is the selected system clock.
- R2: In RUN, a `wait_req` pulse with `deep_sleep` = 0 moves `mode` to HALT at the next clock edge. In HALT, `cpu_clk_en` is 0.
- R3: In RUN, a `wait_req` pulse with `deep_sleep` = 1 moves `mode` to SLEEP at the next clock edge. In SLEEP, `cpu_clk_en` is 0.
- R4: In SLEEP, `osc_run[i]` is 1 only if source i was running in the cycle the sleep strobe was taken and `sleep_stop[i]` is 0. A 1 in `sleep_stop[i]` stops that source during SLEEP.
- R5: In HALT or SLEEP, any bit of `irq_req`, `wdt_nmi` or `rst_req` returns `mode` to RUN at the next clock edge.
- R6: On a wake from HALT, `cpu_clk_en` rises in the same cycle as `mode` becomes RUN. On a wake from SLEEP that is not a reset request, the source enables return with RUN but `cpu_clk_en` rises one cycle later.
- R7: In RUN and HALT, `osc_run` equals `src_en` with the bit of the selected source forced to 1.
- R8: `clk_sel` codes are 0 = internal, 1 = low-speed, 2 = high-speed, 3 = external. A new code takes effect one edge after it is applied in RUN. It is ignored in HALT and SLEEP, and in the RUN cycle that takes a wait strobe.
- R9: `rst_req` overrides every other input. At the next edge, `mode` is RUN, the selected source is 0 and `cpu_clk_en` is 1, even when coming out of SLEEP.
- R10: A `wait_req` strobe that arrives while in HALT or SLEEP has no effect on `mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_req | input | 1 | Wait-for-interrupt/event strobe from the CPU |
| deep_sleep | input | 1 | 1 selects SLEEP, 0 selects HALT on a wait strobe |
| sleep_stop | input | 4 | Per source: 1 = stop in SLEEP, 0 = keep running |
| src_en | input | 4 | Per-source software enable |
| clk_sel | input | 2 | System clock source select |
| irq_req | input | NUM_IRQ | Peripheral interrupt requests |
| wdt_nmi | input | 1 | Watchdog NMI |
| rst_req | input | 1 | Synchronous reset request |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_run | output | 4 | Per-source run enable |
| mode | output | 2 | Current mode (0 RUN, 1 HALT, 2 SLEEP) |

## Verification
Each mode, select and wake decision is registered once, so `mode` and the selected source move one edge after the stimulus. `osc_run` is combinational from that state and from `src_en`/`sleep_stop`, so it follows in the same cycle as the new mode. `cpu_clk_en` takes one extra edge only on a non-reset wake from SLEEP. The bench drives inputs just after each rising edge and compares every output against a behavioural model at the following falling edge. In that way each result is read in the cycle it is due, and none is read a cycle early or late.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   typedef enum logic [1:0] {
      MODE_RUN   = 2'd0,
      MODE_HALT  = 2'd1,
      MODE_SLEEP = 2'd2
   } pmu_mode_e;
endpackage

// File: rtl/pmu_wake_or.sv
module pmu_wake_or #(
   parameter int NUM_IRQ = 8
) (
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic               wdt_nmi,
   input  logic               rst_req,
   output logic               wake
);
   if (NUM_IRQ < 1) begin : g_bad_irq
      $error("pmu_wake_or: NUM_IRQ must be at least 1");
   end

   always_comb wake = (|irq_req) | wdt_nmi | rst_req;
endmodule

// File: rtl/pmu_mode_fsm.sv
module pmu_mode_fsm
   import pmu_pkg::*;
#(
   parameter int NUM_SRC   = 4,
   parameter int RESET_SRC = 0,
   localparam int SEL_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wait_req,
   input  logic               deep_sleep,
   input  logic               wake,
   input  logic               rst_req,
   input  logic [SEL_W-1:0]   clk_sel,
   input  logic [NUM_SRC-1:0] src_en,
   output pmu_mode_e          mode_q,
   output logic [SEL_W-1:0]   sel_q,
   output logic               resume_q,
   output logic [NUM_SRC-1:0] snap_q
);
   localparam logic [SEL_W-1:0]   SEL_RST = SEL_W'(RESET_SRC);
   localparam logic [NUM_SRC-1:0] ONE     = NUM_SRC'(1);

   if (RESET_SRC < 0 || RESET_SRC >= NUM_SRC) begin : g_bad_rst
      $error("pmu_mode_fsm: RESET_SRC out of range");
   end

   logic sel_ok;
   always_comb sel_ok = (int'(clk_sel) < NUM_SRC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_RUN;
         sel_q    <= SEL_RST;
         resume_q <= 1'b0;
         snap_q   <= ONE << SEL_RST;
      end else if (rst_req) begin
         mode_q   <= MODE_RUN;
         sel_q    <= SEL_RST;
         resume_q <= 1'b0;
      end else begin
         unique case (mode_q)
            MODE_RUN: begin
               resume_q <= 1'b0;
               if (wait_req) begin
                  snap_q <= src_en | (ONE << sel_q);
                  mode_q <= deep_sleep ? MODE_SLEEP : MODE_HALT;
               end else if (sel_ok) begin
                  sel_q <= clk_sel;
               end
            end
            MODE_HALT: begin
               if (wake) mode_q <= MODE_RUN;
            end
            MODE_SLEEP: begin
               if (wake) begin
                  mode_q   <= MODE_RUN;
                  resume_q <= 1'b1;
               end
            end
            default: mode_q <= MODE_RUN;
         endcase
      end
   end

   a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_RUN && wait_req && !deep_sleep && !rst_req) |=> mode_q == MODE_HALT);
   a_r3_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_RUN && wait_req && deep_sleep && !rst_req) |=> mode_q == MODE_SLEEP);
   a_r5_wake_to_run: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_RUN && wake) |=> mode_q == MODE_RUN);
   a_r8_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_RUN && !rst_req) |=> $stable(sel_q));
   a_r10_wait_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_RUN && !wake) |=> $stable(mode_q));
endmodule

// File: rtl/pmu_osc_gate.sv
module pmu_osc_gate
   import pmu_pkg::*;
#(
   parameter int NUM_SRC  = 4,
   localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  pmu_mode_e          mode_q,
   input  logic [SEL_W-1:0]   sel_q,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] sleep_stop,
   input  logic [NUM_SRC-1:0] snap_q,
   output logic [NUM_SRC-1:0] osc_run
);
   if (NUM_SRC < 2) begin : g_bad_src
      $error("pmu_osc_gate: NUM_SRC must be at least 2");
   end

   logic asleep;
   always_comb asleep = (mode_q == MODE_SLEEP);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic is_sel;
      always_comb is_sel = (int'(sel_q) == i);
      always_comb osc_run[i] = asleep ? (snap_q[i] & ~sleep_stop[i])
                                      : (src_en[i] | is_sel);
   end

   always_comb begin
      if (asleep) a_r4_sleep_stops: assert ((osc_run & sleep_stop) == '0);
   end
endmodule

// File: rtl/pmu_mode_ctrl.sv
module pmu_mode_ctrl
   import pmu_pkg::*;
#(
   parameter int NUM_SRC   = 4,
   parameter int NUM_IRQ   = 8,
   parameter int RESET_SRC = 0,
   localparam int SEL_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wait_req,
   input  logic               deep_sleep,
   input  logic [NUM_SRC-1:0] sleep_stop,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [SEL_W-1:0]   clk_sel,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic               wdt_nmi,
   input  logic               rst_req,
   output logic               cpu_clk_en,
   output logic [NUM_SRC-1:0] osc_run,
   output logic [1:0]         mode
);
   logic               wake;
   pmu_mode_e          mode_q;
   logic [SEL_W-1:0]   sel_q;
   logic               resume_q;
   logic [NUM_SRC-1:0] snap_q;

   pmu_wake_or #(.NUM_IRQ(NUM_IRQ)) u_wake (
      .irq_req(irq_req), .wdt_nmi(wdt_nmi), .rst_req(rst_req), .wake(wake)
   );

   pmu_mode_fsm #(.NUM_SRC(NUM_SRC), .RESET_SRC(RESET_SRC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .deep_sleep(deep_sleep),
      .wake(wake), .rst_req(rst_req), .clk_sel(clk_sel), .src_en(src_en),
      .mode_q(mode_q), .sel_q(sel_q), .resume_q(resume_q), .snap_q(snap_q)
   );

   pmu_osc_gate #(.NUM_SRC(NUM_SRC)) u_gate (
      .mode_q(mode_q), .sel_q(sel_q), .src_en(src_en),
      .sleep_stop(sleep_stop), .snap_q(snap_q), .osc_run(osc_run)
   );

   always_comb cpu_clk_en = (mode_q == MODE_RUN) && !resume_q;
   always_comb mode       = mode_q;

   a_r6_halt_resume: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_HALT && wake) |=> cpu_clk_en);
   a_r6_sleep_resume: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SLEEP && wake && !rst_req) |=> (!cpu_clk_en && mode_q == MODE_RUN));
   a_r9_reset_req: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> (cpu_clk_en && osc_run[RESET_SRC] && int'(sel_q) == RESET_SRC));
   a_r7_sel_alive: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_SLEEP) |-> osc_run[sel_q]);
endmodule

// File: tb/pmu_mode_ctrl_bench.sv
module pmu_mode_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wait_req = 0, deep_sleep = 0, wdt_nmi = 0, rst_req = 0;
   logic [3:0] sleep_stop = 0, src_en = 0;
   logic [1:0] clk_sel = 0;
   logic [7:0] irq_req = 0;
   logic       cpu_clk_en;
   logic [3:0] osc_run;
   logic [1:0] mode;

   int    n_chk = 0, n_fail = 0;
   string tag = "R1";
   bit    done = 0;

   always #10 clk = ~clk;

   pmu_mode_ctrl u_pmu_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .deep_sleep(deep_sleep),
      .sleep_stop(sleep_stop), .src_en(src_en), .clk_sel(clk_sel),
      .irq_req(irq_req), .wdt_nmi(wdt_nmi), .rst_req(rst_req),
      .cpu_clk_en(cpu_clk_en), .osc_run(osc_run), .mode(mode)
   );

   // behavioural reference: 0 RUN, 1 HALT, 2 SLEEP
   int m_mode, m_sel, m_resume;
   logic [3:0] m_snap;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_sel = 0; m_resume = 0; m_snap = 4'b0001;
      end else if (rst_req) begin
         m_mode = 0; m_sel = 0; m_resume = 0;
      end else if (m_mode == 0) begin
         m_resume = 0;
         if (wait_req) begin
            m_snap = src_en | (4'b0001 << m_sel);
            m_mode = deep_sleep ? 2 : 1;
         end else m_sel = int'(clk_sel);
      end else if ((|irq_req) || wdt_nmi) begin
         if (m_mode == 2) m_resume = 1;
         m_mode = 0;
      end
   end

   task automatic check(string t, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [3:0] e_osc;
         e_osc = (m_mode == 2) ? (m_snap & ~sleep_stop) : (src_en | (4'b0001 << m_sel));
         check({tag, " mode"}, int'(mode), m_mode);
         check({tag, " cpu_clk_en"}, int'(cpu_clk_en), (m_mode == 0 && m_resume == 0) ? 1 : 0);
         check({tag, " osc_run"}, int'(osc_run), int'(e_osc));
      end
   end

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic pulse_wait(bit deep);
      wait_req = 1; deep_sleep = deep; tick(); wait_req = 0;
   endtask

   initial begin
      #(20 * 190000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // R1 reset state, checked while reset is still applied
      #5;
      check("R1 mode in reset", int'(mode), 0);
      check("R1 cpu_clk_en in reset", int'(cpu_clk_en), 1);
      check("R1 osc_run in reset", int'(osc_run), 1);
      tick(2); rst_n = 1; tick(2);
      // R7 enables with internal forced on
      tag = "R7"; src_en = 4'b1010; tick(2); src_en = 4'b0000; tick(2);
      // R8 select changes
      tag = "R8";
      for (int s = 1; s < 4; s++) begin clk_sel = 2'(s); tick(2); end
      clk_sel = 2; tick(2);
      // R2 HALT, R8 ignored in HALT, R10 wait ignored, R5/R6 wake by irq
      tag = "R2"; src_en = 4'b0100; pulse_wait(0); tick(2);
      tag = "R8"; clk_sel = 1; src_en = 4'b0001; tick(2);
      tag = "R10"; pulse_wait(1); tick(1);
      tag = "R6"; irq_req = 8'h02; tick(); irq_req = 0; tick(3);
      // R3/R4 SLEEP, R6 delayed CPU clock, wake by NMI
      tag = "R3"; clk_sel = 3; src_en = 4'b1111; tick(2);
      sleep_stop = 4'b0101; pulse_wait(1); tick(1);
      tag = "R4"; sleep_stop = 4'b1010; tick(1); src_en = 4'b0000; tick(2);
      tag = "R5"; src_en = 4'b0110; wdt_nmi = 1; tick(); wdt_nmi = 0; tick(3);
      // R9 reset request from SLEEP and from RUN with other selection
      tag = "R9"; pulse_wait(1); tick(2);
      rst_req = 1; wait_req = 1; tick(); rst_req = 0; wait_req = 0; tick(2);
      clk_sel = 2; tick(2); rst_req = 1; clk_sel = 3; tick(); rst_req = 0; clk_sel = 0; tick(2);
      // mixed random activity
      tag = "R5 random";
      for (int k = 0; k < 600; k++) begin
         wait_req   = ($urandom_range(0, 9) == 0);
         deep_sleep = $urandom_range(0, 1);
         sleep_stop = 4'($urandom);
         src_en     = 4'($urandom);
         clk_sel    = 2'($urandom);
         irq_req    = ($urandom_range(0, 7) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
         wdt_nmi    = ($urandom_range(0, 15) == 0);
         rst_req    = ($urandom_range(0, 40) == 0);
         tick();
      end
      wait_req = 0; irq_req = 0; wdt_nmi = 0; rst_req = 0; tick(2);
      @(negedge clk); #1;
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule